// File: doc/BRIEF.md
# Set/Clear Peripheral Register File with Interrupt Masking

This block is the software-visible register front end that sits in front of a peripheral function. It is reached over a simple word-wide bus made of a select, a write flag, a byte address and separate write and read data buses. Behind it the peripheral receives one-cycle command strobes, reads a configuration word, and reports events that latch into a status vector.

Software never needs a read-modify-write sequence. Each status bit and each interrupt-mask bit has two addresses of its own: one where a written one sets the bit, and one where a written one clears it. A third address reads the bit back. The single interrupt line is high whenever any latched status bit has its mask bit set. Every register offset is a parameter. All accesses are whole words, and the two lowest address bits are ignored.

Top module: `setclr_regfile`

## Requirements
- R1: After reset the configuration word, the status vector and the interrupt mask are all zero, `irq_out` is low and `cmd_pulse` is all zero.
- R2: A write to the command offset raises `cmd_pulse[i]` for exactly one cycle for each written data bit i that is one. The pulse starts on the cycle after the write edge. Zero bits produce no pulse.
- R3: The configuration offset is read/write over its low MODE_W bits. Read-data bits at and above MODE_W always read 0.
- R4: Writing the status-set offset sets each status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R5: Writing the status-clear offset clears each status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R6: Writes to the mask-set offset set interrupt-mask bits and writes to the mask-clear offset clear them, following the same one-bits rule. The mask reads back at the mask-read offset, in bits [NUM_STAT-1:0].
- R7: `irq_out` is high exactly when some bit i has both status[i] and mask[i] set.
- R8: A one on `hw_event[i]` at a clock edge sets status[i]. This holds even when a clear of the same bit is written on that edge, so the event wins.
- R9: Reads of the command, status-set, status-clear, mask-set, mask-clear and unmapped offsets return 0. Writes to the status-read and mask-read offsets change no state.
- R10: Address bits [1:0] are ignored, so any byte address inside a word reaches that word's register.
- R11: `bus_rdata` is 0 whenever there is no read access, that is when `bus_sel` is low or `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this register file |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| hw_event | input | NUM_STAT | Peripheral event inputs that set status bits |
| cmd_pulse | output | NUM_CMD | One-cycle command strobes |
| irq_out | output | 1 | Interrupt source line |

## Verification
The assertions check on every clock several things: every command strobe follows a command write on the previous edge, set writes and hardware events always leave their bits set, a clear write leaves its bits clear when no event is raised, the mask holds steady without a mask write, and read data is zero outside read accesses. Some behaviours are shown only by the bench's sweeps. These are the exact OR-of-AND value of the interrupt over all mask values, read-back values at each offset, the ignoring of writes to read-only offsets, address aliasing within a word, and the zeroing of configuration bits above the implemented width.

// File: rtl/setclr_pkg.sv
package setclr_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_MODE,
    SEL_SSET,
    SEL_SCLR,
    SEL_SRD,
    SEL_MSET,
    SEL_MCLR,
    SEL_MRD
  } reg_sel_e;

  // Next value of a set/clear bit vector: software set, then software clear,
  // then hardware set on top so that an event is never lost.
  function automatic logic [63:0] setclr_next(
    input logic [63:0] cur,
    input logic [63:0] sw_set,
    input logic [63:0] sw_clr,
    input logic [63:0] hw_set
  );
    return ((cur | sw_set) & ~sw_clr) | hw_set;
  endfunction

  // Interrupt source: any enabled pending bit.
  function automatic logic any_masked(
    input logic [63:0] stat,
    input logic [63:0] mask
  );
    return |(stat & mask);
  endfunction

endpackage

// File: rtl/setclr_decode.sv
module setclr_decode
  import setclr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFS_CMD  = 'h00,
  parameter int unsigned OFS_MODE = 'h04,
  parameter int unsigned OFS_SSET = 'h10,
  parameter int unsigned OFS_SCLR = 'h14,
  parameter int unsigned OFS_SRD  = 'h18,
  parameter int unsigned OFS_MSET = 'h20,
  parameter int unsigned OFS_MCLR = 'h24,
  parameter int unsigned OFS_MRD  = 'h28
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              wr_cmd,
  output logic              wr_mode,
  output logic              wr_sset,
  output logic              wr_sclr,
  output logic              wr_mset,
  output logic              wr_mclr,
  output logic              rd_go
);

  localparam logic [ADDR_W-1:0] W_CMD  = ADDR_W'(OFS_CMD  >> 2);
  localparam logic [ADDR_W-1:0] W_MODE = ADDR_W'(OFS_MODE >> 2);
  localparam logic [ADDR_W-1:0] W_SSET = ADDR_W'(OFS_SSET >> 2);
  localparam logic [ADDR_W-1:0] W_SCLR = ADDR_W'(OFS_SCLR >> 2);
  localparam logic [ADDR_W-1:0] W_SRD  = ADDR_W'(OFS_SRD  >> 2);
  localparam logic [ADDR_W-1:0] W_MSET = ADDR_W'(OFS_MSET >> 2);
  localparam logic [ADDR_W-1:0] W_MCLR = ADDR_W'(OFS_MCLR >> 2);
  localparam logic [ADDR_W-1:0] W_MRD  = ADDR_W'(OFS_MRD  >> 2);

  logic [ADDR_W-1:0] word_idx;
  logic              wr_go;

  // Word-only access: drop the byte lane bits.
  assign word_idx = bus_addr >> 2;
  assign wr_go    = bus_sel & bus_wr;
  assign rd_go    = bus_sel & ~bus_wr;

  always_comb begin
    if      (word_idx == W_CMD)  sel = SEL_CMD;
    else if (word_idx == W_MODE) sel = SEL_MODE;
    else if (word_idx == W_SSET) sel = SEL_SSET;
    else if (word_idx == W_SCLR) sel = SEL_SCLR;
    else if (word_idx == W_SRD)  sel = SEL_SRD;
    else if (word_idx == W_MSET) sel = SEL_MSET;
    else if (word_idx == W_MCLR) sel = SEL_MCLR;
    else if (word_idx == W_MRD)  sel = SEL_MRD;
    else                         sel = SEL_NONE;
  end

  assign wr_cmd  = wr_go && (sel == SEL_CMD);
  assign wr_mode = wr_go && (sel == SEL_MODE);
  assign wr_sset = wr_go && (sel == SEL_SSET);
  assign wr_sclr = wr_go && (sel == SEL_SCLR);
  assign wr_mset = wr_go && (sel == SEL_MSET);
  assign wr_mclr = wr_go && (sel == SEL_MCLR);

endmodule

// File: rtl/setclr_bank.sv
module setclr_bank
  import setclr_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter bit          HW_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);

  logic [W-1:0] sw_set;
  logic [W-1:0] sw_clr;
  logic [W-1:0] hw_eff;
  logic [W-1:0] nxt;
  logic [63:0]  nxt_wide;

  assign sw_set = set_en ? wbits : '0;
  assign sw_clr = clr_en ? wbits : '0;

  generate
    if (HW_EN) begin : g_hw
      assign hw_eff = hw_set;
    end else begin : g_nohw
      assign hw_eff = hw_set & '0;
    end
  endgenerate

  assign nxt_wide = setclr_next(64'(q), 64'(sw_set), 64'(sw_clr), 64'(hw_eff));
  assign nxt      = nxt_wide[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/setclr_pulse.sv
module setclr_pulse #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] bits,
  output logic [W-1:0] pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pulse <= '0;
    else if (fire) pulse <= bits;
    else           pulse <= '0;
  end

endmodule

// File: rtl/setclr_regfile.sv
module setclr_regfile
  import setclr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CMD  = 4,
  parameter int unsigned NUM_STAT = 8,
  parameter int unsigned MODE_W   = 8,
  parameter int unsigned OFS_CMD  = 'h00,
  parameter int unsigned OFS_MODE = 'h04,
  parameter int unsigned OFS_SSET = 'h10,
  parameter int unsigned OFS_SCLR = 'h14,
  parameter int unsigned OFS_SRD  = 'h18,
  parameter int unsigned OFS_MSET = 'h20,
  parameter int unsigned OFS_MCLR = 'h24,
  parameter int unsigned OFS_MRD  = 'h28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_STAT-1:0] hw_event,
  output logic [NUM_CMD-1:0]  cmd_pulse,
  output logic                irq_out
);

  reg_sel_e            sel;
  logic                ev_cmd_wr;
  logic                ev_mode_wr;
  logic                ev_sset_wr;
  logic                ev_sclr_wr;
  logic                ev_mset_wr;
  logic                ev_mclr_wr;
  logic                ev_rd;
  logic [MODE_W-1:0]   mode_q;
  logic [NUM_STAT-1:0] stat_q;
  logic [NUM_STAT-1:0] mask_q;

  setclr_decode #(
    .ADDR_W  (ADDR_W),
    .OFS_CMD (OFS_CMD),
    .OFS_MODE(OFS_MODE),
    .OFS_SSET(OFS_SSET),
    .OFS_SCLR(OFS_SCLR),
    .OFS_SRD (OFS_SRD),
    .OFS_MSET(OFS_MSET),
    .OFS_MCLR(OFS_MCLR),
    .OFS_MRD (OFS_MRD)
  ) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .sel     (sel),
    .wr_cmd  (ev_cmd_wr),
    .wr_mode (ev_mode_wr),
    .wr_sset (ev_sset_wr),
    .wr_sclr (ev_sclr_wr),
    .wr_mset (ev_mset_wr),
    .wr_mclr (ev_mclr_wr),
    .rd_go   (ev_rd)
  );

  setclr_pulse #(.W(NUM_CMD)) u_cmd (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (ev_cmd_wr),
    .bits (bus_wdata[NUM_CMD-1:0]),
    .pulse(cmd_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= '0;
    else if (ev_mode_wr) mode_q <= bus_wdata[MODE_W-1:0];
  end

  setclr_bank #(.W(NUM_STAT), .HW_EN(1'b1)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_en(ev_sset_wr),
    .clr_en(ev_sclr_wr),
    .wbits (bus_wdata[NUM_STAT-1:0]),
    .hw_set(hw_event),
    .q     (stat_q)
  );

  setclr_bank #(.W(NUM_STAT), .HW_EN(1'b0)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .set_en(ev_mset_wr),
    .clr_en(ev_mclr_wr),
    .wbits (bus_wdata[NUM_STAT-1:0]),
    .hw_set(hw_event),
    .q     (mask_q)
  );

  assign irq_out = any_masked(64'(stat_q), 64'(mask_q));

  always_comb begin
    bus_rdata = '0;
    if (ev_rd) begin
      unique case (sel)
        SEL_MODE: bus_rdata[MODE_W-1:0]   = mode_q;
        SEL_SRD:  bus_rdata[NUM_STAT-1:0] = stat_q;
        SEL_MRD:  bus_rdata[NUM_STAT-1:0] = mask_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/setclr_checker.sv
module setclr_checker #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CMD  = 4,
  parameter int unsigned NUM_STAT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_STAT-1:0] hw_event,
  input logic [NUM_CMD-1:0]  cmd_pulse,
  input logic                irq_out,
  input logic                ev_cmd_wr,
  input logic                ev_sset_wr,
  input logic                ev_sclr_wr,
  input logic                ev_mset_wr,
  input logic                ev_mclr_wr,
  input logic [NUM_STAT-1:0] stat_q,
  input logic [NUM_STAT-1:0] mask_q
);

  p_cmd_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> $past(ev_cmd_wr));

  p_cmd_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_wr |=> (cmd_pulse == $past(bus_wdata[NUM_CMD-1:0])));

  p_set_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sset_wr |=> ((stat_q & $past(bus_wdata[NUM_STAT-1:0])) == $past(bus_wdata[NUM_STAT-1:0])));

  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sclr_wr && (hw_event == '0)) |=> ((stat_q & $past(bus_wdata[NUM_STAT-1:0])) == '0));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_mset_wr || ev_mclr_wr) |=> $stable(mask_q));

  p_irq_needs_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((mask_q != '0) && (stat_q != '0)));

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != '0) |=> ((stat_q & $past(hw_event)) == $past(hw_event)));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == '0));

endmodule

bind setclr_regfile setclr_checker #(
  .DATA_W  (DATA_W),
  .NUM_CMD (NUM_CMD),
  .NUM_STAT(NUM_STAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .hw_event  (hw_event),
  .cmd_pulse (cmd_pulse),
  .irq_out   (irq_out),
  .ev_cmd_wr (ev_cmd_wr),
  .ev_sset_wr(ev_sset_wr),
  .ev_sclr_wr(ev_sclr_wr),
  .ev_mset_wr(ev_mset_wr),
  .ev_mclr_wr(ev_mclr_wr),
  .stat_q    (stat_q),
  .mask_q    (mask_q)
);

// File: tb/sim_setclr_regfile.sv
`timescale 1ns/1ps
module sim_setclr_regfile;

  localparam int A_CMD  = 'h00;
  localparam int A_MODE = 'h04;
  localparam int A_SSET = 'h10;
  localparam int A_SCLR = 'h14;
  localparam int A_SRD  = 'h18;
  localparam int A_MSET = 'h20;
  localparam int A_MCLR = 'h24;
  localparam int A_MRD  = 'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  hw_event = '0;
  logic [3:0]  cmd_pulse;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_stat = '0;
  logic [7:0] m_mask = '0;
  logic [7:0] m_mode = '0;

  always #4 clk = ~clk;

  setclr_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_event(hw_event), .cmd_pulse(cmd_pulse), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write on one edge with an optional simultaneous hardware event.
  task automatic wr(input int a, input logic [31:0] d, input logic [7:0] hw);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d; hw_event = hw;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; hw_event = '0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(a);
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic irq_model(input logic [7:0] s, input logic [7:0] m);
    for (int b = 0; b < 8; b++) if (s[b] && m[b]) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check("R1 irq", {31'b0, irq_out}, 0);
    check("R1 cmd", {28'b0, cmd_pulse}, 0);
    rst_n = 1'b1;
    rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 status", A_SRD, 0);
    rd_chk("R1 mask", A_MRD, 0);

    // R2: command pulses, every 4-bit pattern
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(A_CMD); bus_wdata = 32'(p) | 32'hFFF0_0000;
      #1 check("R2 no early pulse", {28'b0, cmd_pulse}, 0);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      check("R2 pulse", {28'b0, cmd_pulse}, 32'(p));
      @(negedge clk);
      check("R2 pulse ends", {28'b0, cmd_pulse}, 0);
    end

    // R3 / R10: mode read/write, upper bits zero, byte aliasing
    for (int v = 0; v < 16; v++) begin
      logic [31:0] d = 32'hA5C3_0000 ^ (32'(v) * 32'h0101_0111);
      wr(A_MODE + (v % 4), d, 8'h00);
      m_mode = d[7:0];
      rd_chk("R3 mode readback", A_MODE, {24'b0, m_mode});
      rd_chk("R10 mode alias", A_MODE + 3 - (v % 4), {24'b0, m_mode});
    end

    // R4 / R5: set and clear sweeps
    for (int i = 0; i < 32; i++) begin
      logic [7:0] s = 8'((i * 37 + 5) & 255);
      logic [7:0] c = 8'((i * 91 + 3) & 255);
      wr(A_SSET, {24'hFFFFFF, s}, 8'h00);
      m_stat = m_stat | s;
      rd_chk("R4 status set", A_SRD, {24'b0, m_stat});
      wr(A_SCLR + (i % 4), {24'h0, c}, 8'h00);
      m_stat = m_stat & ~c;
      rd_chk("R5 status clear", A_SRD, {24'b0, m_stat});
    end

    // R6 / R7: every mask value against two status values
    for (int k = 0; k < 2; k++) begin
      wr(A_SCLR, 32'hFF, 8'h00);
      wr(A_SSET, (k == 0) ? 32'h81 : 32'h3C, 8'h00);
      m_stat = (k == 0) ? 8'h81 : 8'h3C;
      for (int m = 0; m < 256; m++) begin
        wr(A_MCLR, 32'hFF, 8'h00);
        wr(A_MSET, 32'(m), 8'h00);
        m_mask = 8'(m);
        @(negedge clk);
        check("R7 irq", {31'b0, irq_out}, {31'b0, irq_model(m_stat, m_mask)});
        if ((m % 17) == 0) rd_chk("R6 mask readback", A_MRD, {24'b0, m_mask});
      end
    end
    wr(A_MCLR, 32'h0F, 8'h00);
    m_mask = m_mask & 8'hF0;
    rd_chk("R6 mask clear", A_MRD, {24'b0, m_mask});

    // R8: hardware event, alone and against a clear of the same bit
    wr(A_SCLR, 32'hFF, 8'h00);
    m_stat = 0;
    wr(A_SCLR, 32'h00, 8'h24);
    rd_chk("R8 event sets", A_SRD, 32'h24);
    wr(A_SCLR, 32'hFF, 8'h81);
    rd_chk("R8 event beats clear", A_SRD, 32'h81);
    m_stat = 8'h81;

    // R9: write-only offsets read 0, read-only offsets ignore writes
    rd_chk("R9 cmd reads 0", A_CMD, 0);
    rd_chk("R9 sset reads 0", A_SSET, 0);
    rd_chk("R9 sclr reads 0", A_SCLR, 0);
    rd_chk("R9 mset reads 0", A_MSET, 0);
    rd_chk("R9 mclr reads 0", A_MCLR, 0);
    rd_chk("R9 unmapped reads 0", 'h3C, 0);
    wr(A_SRD, 32'h7E, 8'h00);
    rd_chk("R9 status write ignored", A_SRD, {24'b0, m_stat});
    wr(A_MRD, 32'h0F, 8'h00);
    rd_chk("R9 mask write ignored", A_MRD, {24'b0, m_mask});

    // R11: no read access, no data
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'(A_SRD);
    #1 check("R11 idle rdata", bus_rdata, 0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(A_MODE); bus_wdata = 32'h0;
    #1 check("R11 write rdata", bus_rdata, 0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule